// File: doc/BRIEF.md
# Serial Clock-Decoupling Elastic FIFO

This block is a one-bit-wide elastic buffer between two clock domains. A framer supplies a serial NRZ bit stream together with its own transmit clock. The line side reads that stream on an internal reference clock of the same nominal rate. The two clocks share a source, but their phase may wander slowly over time. The buffer holds sixteen bits and is kept about half full, so it can absorb a bounded amount of drift in either direction without losing or repeating a bit.

When the drift grows too large, the buffer fills on the write side or runs dry on the read side. Either event sets a sticky error flag, which system logic can use to raise an interrupt, and the serial output is forced low. Two events re-centre the pointers and clear the flag:

- a one-cycle re-centre pulse;
- the falling edge of a transmit loss-of-lock indication.

A bypass input selects plesiochronous operation. In that mode the buffer is skipped and the output follows the input bit after one write-clock register.

Top module: `serial_elastic_fifo`

## Requirements
- R1: The input bit is captured on the rising edge of `wr_clk`. With `bypass_en` low, `ser_out` carries the same bits in the same order, retimed to `rd_clk`, with no bit dropped or repeated.
- R2: After a re-centre, the two clocks may drift apart by at least ±25.6 ns. `slip_err` stays 0 and the stream is delivered intact. Depth is 16 entries, and the read pointer is placed 8 entries behind the write pointer.
- R3: If the write side would write into a full buffer (the write clock is persistently faster), `slip_err` goes to 1.
- R4: If the read side finds the buffer empty (the write clock is persistently slower), `slip_err` goes to 1 at the next `rd_clk` edge.
- R5: `slip_err` is sticky. It stays 1 after the drift condition is gone, and it stays 1 in the cycle right after a re-centre request. It falls only in the cycle after the re-centre handshake completes.
- R6: A `recenter_pulse` that is high for one `rd_clk` cycle re-centres the buffer. It clears `slip_err` within 16 `rd_clk` cycles.
- R7: A 1-to-0 transition of `lock_lost` re-centres the buffer exactly like `recenter_pulse`. A 0-to-1 transition has no effect on `slip_err`.
- R8: With `bypass_en` low, `ser_out` is 0 in every cycle after one in which `slip_err` is 1. It is also 0 while a re-centre handshake is in progress.
- R9: With `bypass_en` high, `ser_out` equals the value of `ser_in` captured at the previous `wr_clk` rising edge, whatever the state of the buffer.
- R10: While `rd_rst_n` and `wr_rst_n` are low (active-low, asynchronous), and in the first cycle after release, `ser_out` is 0 and `slip_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Transmit clock supplied with the serial data |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| ser_in | input | 1 | Serial NRZ data bit from the framer |
| rd_clk | input | 1 | Internal reference transmit clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| recenter_pulse | input | 1 | One-cycle request to re-centre and clear the error (read domain) |
| lock_lost | input | 1 | Transmit loss-of-lock level; its falling edge re-centres (read domain) |
| bypass_en | input | 1 | 1 = plesiochronous mode, the buffer is skipped |
| ser_out | output | 1 | Serial data bit toward the line encoder |
| slip_err | output | 1 | Sticky overflow/underflow flag (read domain) |

## Verification
The bench steps the write-clock period off the read-clock period to create controlled drift.

- Small offsets that accumulate about 24 ns must leave the stream intact. A design with the centre offset wrong, or with a bad pointer comparison, would slip a bit and fail the stream match.
- Large offsets must set the flag through both the full path and the empty path. A design that detected only one side would miss one of them.
- The flag is probed after the drift stops, and in the cycle right after a re-centre request. A non-sticky flag, or one cleared on the request instead of on completion, would read 0 there.
- The rising edge of the lock indication is applied while an error is pending, to catch a detector that fires on either edge.
- Bypass is checked while the buffer is in error. This catches an output mux that still gates data with the error state.

// File: rtl/sefifo_pkg.sv
package sefifo_pkg;

  // Widest pointer the helper functions handle (depth up to 128).
  localparam int PTR_MAX = 8;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'd0,
    RC_REQ   = 2'd1,
    RC_DRAIN = 2'd2
  } rc_state_t;

  function automatic logic [PTR_MAX-1:0] bin2gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Occupancy seen from the side owning pointer a.
  function automatic logic [PTR_MAX-1:0] ptr_gap(input logic [PTR_MAX-1:0] a,
                                                 input logic [PTR_MAX-1:0] b);
    return a - b;
  endfunction

endpackage

// File: rtl/sefifo_sync.sv
module sefifo_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sefifo_wr_side.sv
module sefifo_wr_side
  import sefifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CENTER = DEPTH / 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic [PW-1:0]    rptr_gray_s,
  input  logic             rc_req_s,
  output logic [DEPTH-1:0] store,
  output logic [PW-1:0]    wptr_gray,
  output logic             ack,
  output logic             ovf,
  output logic             din_q
);

  logic [PW-1:0] wptr_bin;
  logic [PW-1:0] rbin;
  logic [PW-1:0] gap;
  logic [PW-1:0] jump_bin;
  logic          jump_evt;
  logic          full_evt;

  assign rbin     = PW'(gray2bin(PTR_MAX'(rptr_gray_s)));
  assign gap      = PW'(ptr_gap(PTR_MAX'(wptr_bin), PTR_MAX'(rbin)));
  assign jump_bin = rbin + PW'(CENTER);
  // First write-domain cycle that sees the re-centre request.
  assign jump_evt = rc_req_s & ~ack;
  assign full_evt = ~jump_evt & (gap == PW'(DEPTH));

  always_ff @(posedge clk or negedge wr_rst_guard) begin
    if (!wr_rst_guard) begin
      wptr_bin  <= PW'(CENTER);
      wptr_gray <= PW'(bin2gray(PTR_MAX'(CENTER)));
      store     <= '0;
      ack       <= 1'b0;
      ovf       <= 1'b0;
      din_q     <= 1'b0;
    end else begin
      din_q <= ser_in;
      ack   <= rc_req_s;
      if (jump_evt) begin
        wptr_bin  <= jump_bin;
        wptr_gray <= PW'(bin2gray(PTR_MAX'(jump_bin)));
        ovf       <= 1'b0;
      end else if (full_evt) begin
        ovf <= 1'b1;
      end else begin
        store[wptr_bin[AW-1:0]] <= ser_in;
        wptr_bin  <= wptr_bin + PW'(1);
        wptr_gray <= PW'(bin2gray(PTR_MAX'(wptr_bin + PW'(1))));
      end
    end
  end

  logic wr_rst_guard;
  assign wr_rst_guard = rst_n;

endmodule

// File: rtl/sefifo_rd_side.sv
module sefifo_rd_side
  import sefifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] store,
  input  logic [PW-1:0]    wptr_gray_s,
  input  logic             ovf_s,
  input  logic             ack_s,
  input  logic             recenter_pulse,
  input  logic             lock_lost,
  output logic [PW-1:0]    rptr_gray,
  output logic             rc_req,
  output logic             rd_bit,
  output logic             slip_err,
  output logic             rc_busy,
  output logic             rc_drain,
  output logic             rc_done,
  output logic             under_evt
);

  rc_state_t     st, st_n;
  logic          pend, pend_n;
  logic          lock_q;
  logic          trig;
  logic          empty;
  logic          reading;
  logic [PW-1:0] rptr_bin;

  assign trig      = recenter_pulse | (lock_q & ~lock_lost);
  assign rc_busy   = (st == RC_REQ);
  assign rc_drain  = (st == RC_DRAIN);
  assign rc_done   = rc_busy & ack_s;
  assign empty     = (rptr_gray == wptr_gray_s);
  assign under_evt = ~rc_busy & ~slip_err & empty;
  assign reading   = ~rc_busy & ~slip_err & ~empty;

  // Four-phase handshake: raise request, wait ack, drop, wait ack low.
  always_comb begin
    st_n   = st;
    pend_n = pend;
    case (st)
      RC_IDLE: if (trig) st_n = RC_REQ;
      RC_REQ: begin
        if (ack_s) begin
          st_n   = RC_DRAIN;
          pend_n = 1'b0;
        end
      end
      RC_DRAIN: begin
        if (trig) pend_n = 1'b1;
        if (!ack_s) begin
          st_n   = (pend || trig) ? RC_REQ : RC_IDLE;
          pend_n = 1'b0;
        end
      end
      default: st_n = RC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RC_IDLE;
      pend      <= 1'b0;
      rc_req    <= 1'b0;
      lock_q    <= 1'b0;
      slip_err  <= 1'b0;
      rd_bit    <= 1'b0;
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else begin
      st     <= st_n;
      pend   <= pend_n;
      rc_req <= (st_n == RC_REQ);
      lock_q <= lock_lost;
      if (rc_done)                slip_err <= 1'b0;
      else if (ovf_s || under_evt) slip_err <= 1'b1;
      if (reading) begin
        rd_bit    <= store[rptr_bin[AW-1:0]];
        rptr_bin  <= rptr_bin + PW'(1);
        rptr_gray <= PW'(bin2gray(PTR_MAX'(rptr_bin + PW'(1))));
      end else begin
        rd_bit <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo
  import sefifo_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CENTER      = DEPTH / 2
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic ser_in,
  input  logic rd_clk,
  input  logic rd_rst_n,
  input  logic recenter_pulse,
  input  logic lock_lost,
  input  logic bypass_en,
  output logic ser_out,
  output logic slip_err
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] WGRAY_RST = PW'(bin2gray(PTR_MAX'(CENTER)));

  logic [DEPTH-1:0] store;
  logic [PW-1:0]    wptr_gray, wptr_gray_s;
  logic [PW-1:0]    rptr_gray, rptr_gray_s;
  logic             rc_req, rc_req_s;
  logic             ack, ack_s;
  logic             ovf, ovf_s;
  logic             din_q;
  logic             rd_bit;
  logic             rc_busy, rc_drain, rc_done, under_evt;

  sefifo_wr_side #(.DEPTH(DEPTH), .CENTER(CENTER)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .ser_in(ser_in),
    .rptr_gray_s(rptr_gray_s), .rc_req_s(rc_req_s),
    .store(store), .wptr_gray(wptr_gray), .ack(ack), .ovf(ovf), .din_q(din_q)
  );

  sefifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .store(store),
    .wptr_gray_s(wptr_gray_s), .ovf_s(ovf_s), .ack_s(ack_s),
    .recenter_pulse(recenter_pulse), .lock_lost(lock_lost),
    .rptr_gray(rptr_gray), .rc_req(rc_req), .rd_bit(rd_bit),
    .slip_err(slip_err), .rc_busy(rc_busy), .rc_drain(rc_drain),
    .rc_done(rc_done), .under_evt(under_evt)
  );

  // Toward the read domain.
  sefifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(WGRAY_RST)) u_sync_wptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_s));
  sefifo_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_flags (
    .clk(rd_clk), .rst_n(rd_rst_n), .d({ack, ovf}), .q({ack_s, ovf_s}));

  // Toward the write domain.
  sefifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_rptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_s));
  sefifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_req (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rc_req), .q(rc_req_s));

  assign ser_out = bypass_en ? din_q : rd_bit;

endmodule

// File: rtl/sefifo_checker.sv
module sefifo_checker (
  input logic wr_clk,
  input logic wr_rst_n,
  input logic rd_clk,
  input logic rd_rst_n,
  input logic ser_in,
  input logic ser_out,
  input logic bypass_en,
  input logic lock_lost,
  input logic slip_err,
  input logic rd_bit,
  input logic rc_busy,
  input logic rc_drain,
  input logic rc_done,
  input logic under_evt
);

  // R8: an error pending silences the buffered bit one cycle later
  a_r8_quiet_on_error: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_err |=> !rd_bit);

  // R8: re-centre in progress silences the buffered bit
  a_r8_quiet_on_recenter: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rc_busy |=> !rd_bit);

  // R5: flag holds until the handshake completes
  a_r5_sticky_error: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_err && !rc_done |=> slip_err);

  // R6: flag falls only after a completed re-centre
  a_r6_clear_on_done: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(slip_err) |-> $past(rc_done));

  // R4: an empty read sets the flag
  a_r4_underflow_flags: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    under_evt |=> slip_err);

  // R7: falling lock indication starts a re-centre from idle
  a_r7_lock_fall_starts: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(lock_lost) && !rc_busy && !rc_drain |=> rc_busy);

  // R9: bypass output is the input one write cycle late
  a_r9_bypass_path: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    bypass_en && $past(bypass_en) && $past(wr_rst_n) |-> ser_out == $past(ser_in));

endmodule

bind serial_elastic_fifo sefifo_checker u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .ser_in(ser_in), .ser_out(ser_out), .bypass_en(bypass_en),
  .lock_lost(lock_lost), .slip_err(slip_err), .rd_bit(rd_bit),
  .rc_busy(rc_busy), .rc_drain(rc_drain), .rc_done(rc_done),
  .under_evt(under_evt)
);

// File: tb/serial_elastic_fifo_bench.sv
`timescale 1ps/1ps
module serial_elastic_fifo_bench;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic ser_in = 1'b0, recenter_pulse = 1'b0, lock_lost = 1'b0, bypass_en = 1'b0;
  logic ser_out, slip_err;

  int whp = 5000;          // write half-period in ps
  int tests = 0, fails = 0;
  bit finished = 0;

  serial_elastic_fifo u_serial_elastic_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .ser_in(ser_in),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .recenter_pulse(recenter_pulse),
    .lock_lost(lock_lost), .bypass_en(bypass_en),
    .ser_out(ser_out), .slip_err(slip_err)
  );

  // 100 MHz read clock; write clock with adjustable period.
  always #5000 rd_clk = ~rd_clk;
  initial begin
    #2300;
    forever begin
      #(whp) wr_clk = ~wr_clk;
    end
  end

  // Stimulus stream and capture histories (circular).
  logic [14:0] lfsr = 15'h1;
  bit wb [512];
  bit rb [512];
  bit bb [512];
  int wcnt = 0, rcnt = 0, bcnt = 0;

  always @(negedge wr_clk) begin
    bb[bcnt % 512] = ser_out;
    bcnt++;
    lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
    ser_in = lfsr[0];
    wb[wcnt % 512] = lfsr[0];
    wcnt++;
  end

  always @(negedge rd_clk) begin
    rb[rcnt % 512] = ser_out;
    rcnt++;
  end

  // Vectors: write half-period (ps), read cycles to run, expected flag.
  localparam int VEC [6][3] = '{
    '{5000, 300, 0}, '{5040, 300, 0}, '{4960, 300, 0},
    '{4750, 400, 1}, '{5250, 400, 1}, '{5020, 200, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Last 32 captured bits must equal some contiguous 32 written bits.
  function automatic bit stream_ok(input bit use_b);
    int n = use_b ? bcnt : rcnt;
    for (int j = wcnt - 1; j >= wcnt - 160 && j >= 40; j--) begin
      bit m = 1;
      for (int i = 0; i < 32; i++) begin
        bit h = use_b ? bb[(n - 1 - i) % 512] : rb[(n - 1 - i) % 512];
        if (h != wb[(j - i) % 512]) m = 0;
      end
      if (m) return 1;
    end
    return 0;
  endfunction

  task automatic wait_r(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic pulse();
    @(negedge rd_clk) recenter_pulse = 1'b1;
    @(negedge rd_clk) recenter_pulse = 1'b0;
  endtask

  initial begin
    wait_r(3);
    chk("R10 reset ser_out", ser_out, 0);
    chk("R10 reset slip_err", slip_err, 0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    wait_r(1);
    chk("R10 after release ser_out", ser_out, 0);
    chk("R10 after release slip_err", slip_err, 0);

    for (int k = 0; k < 6; k++) begin
      whp = VEC[k][0];
      pulse();
      wait_r(30);
      chk("R6 cleared after recenter", slip_err, 0);
      wait_r(VEC[k][1]);
      #1;
      if (VEC[k][2] == 0) begin
        chk("R2 no slip within drift", slip_err, 0);
        chk("R1 stream intact", stream_ok(1'b0), 1);
      end else if (VEC[k][0] < 5000) begin
        chk("R3 overflow flagged", slip_err, 1);
      end else begin
        chk("R4 underflow flagged", slip_err, 1);
      end
    end

    // R5: sticky after drift stops; R8 output quiet while pending
    whp = 4750;
    pulse();
    wait_r(300);
    chk("R3 overflow again", slip_err, 1);
    whp = 5000;
    wait_r(50);
    chk("R5 flag sticky", slip_err, 1);
    begin
      int ones = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge rd_clk);
        if (ser_out) ones++;
      end
      chk("R8 output zero during error", ones, 0);
    end
    @(negedge rd_clk) recenter_pulse = 1'b1;
    @(negedge rd_clk) recenter_pulse = 1'b0;
    chk("R5 still set right after request", slip_err, 1);
    wait_r(16);
    chk("R6 cleared within 16 cycles", slip_err, 0);
    wait_r(200);
    #1;
    chk("R1 stream intact after recenter", stream_ok(1'b0), 1);

    // R8: quiet during handshake even without error
    @(negedge rd_clk) recenter_pulse = 1'b1;
    @(negedge rd_clk) recenter_pulse = 1'b0;
    @(negedge rd_clk);
    chk("R8 output zero during recenter", ser_out, 0);
    wait_r(30);

    // R7: lock indication edges
    whp = 4750;
    pulse();
    wait_r(300);
    whp = 5000;
    chk("R3 overflow before lock test", slip_err, 1);
    @(negedge rd_clk) lock_lost = 1'b1;
    wait_r(20);
    chk("R7 rising lock edge ignored", slip_err, 1);
    @(negedge rd_clk) lock_lost = 1'b0;
    wait_r(20);
    chk("R7 falling lock edge clears", slip_err, 0);

    // R9: bypass while the buffer is in error
    whp = 5250;
    pulse();
    wait_r(400);
    chk("R4 underflow before bypass", slip_err, 1);
    whp = 5000;
    bypass_en = 1'b1;
    repeat (100) @(negedge wr_clk);
    #1;
    chk("R9 bypass stream", stream_ok(1'b1), 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule